// File: doc/BRIEF.md
# Line-Rate Word Replication Adapter

This block lets a MAC that runs slower than the line exchange 32-bit words with a PHY-side lane that always moves one word per line clock. For each of six link speeds it picks a repeat count N. On transmit it accepts one MAC word every N line clocks and drives that word onto the line lane for N consecutive cycles. On receive it keeps the first word of every N-word group and drops the other N-1 copies. A lane word is 32 data bits plus 4 control bits, one control bit per byte, in the usual 10-gigabit media-independent style.

The speed code is a plain input that a control register outside the block drives. A new code takes effect only when the current group ends. After the switch the block runs one realignment group of the new length. During that group it sends idle words and takes no word on either side. Then it resumes normal traffic with the group counter starting from zero.

Transmit back-pressure follows these rules. `mac_tx_ready` is a one-cycle strobe. A word moves only in a cycle where both `mac_tx_valid` and `mac_tx_ready` are high. The source may hold a word with valid high for as long as it likes, and cycles without ready do not consume it. If valid is low in a ready cycle, that group carries idle words. Receive has no back-pressure: `mac_rx_valid` is a one-cycle strobe, and the word is lost if the sink does not take it.

Top module: `rate_repl_adapter`

## Requirements
- R1: Reset state. While reset is active and in the first cycle after it, `mac_tx_ready` is 1 and `mac_rx_valid` is 0. The line transmit lane carries the idle word (control 4'hF, data 32'h07070707), and the active speed is code 5.
- R2: Speed code to repeat count: 0 gives 1000, 1 gives 100, 2 gives 10, 3 gives 4, 4 gives 2, and 5 gives 1. Codes 6 and 7 behave as a repeat count of 1.
- R3: Outside realignment, `mac_tx_ready` is high for exactly one cycle in every N cycles.
- R4: A word accepted in a cycle with valid and ready both high appears on `phy_tx_ctrl`/`phy_tx_data` for the N cycles that start with the next cycle.
- R5: If `mac_tx_valid` is low in a ready cycle, the line lane carries the idle word (control 4'hF, data 32'h07070707) for the next N cycles.
- R6: The line receive word present in a ready cycle appears on `mac_rx_ctrl`/`mac_rx_data` in the next cycle, with `mac_rx_valid` high for that single cycle. Line words from all other cycles are discarded, and `mac_rx_valid` stays low in those cycles.
- R7: A change on `spd_sel` made at any point inside a group does not shorten or lengthen that group. The new count applies only after the group's last cycle.
- R8: After a speed switch, the block runs one realignment group of N_new cycles. In that group `mac_tx_ready` stays low, any offered transmit word is ignored, the line lane carries idle words and `mac_rx_valid` stays low. The next ready strobe comes in the group's last cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spd_sel | input | 3 | Requested speed code from a control register |
| mac_tx_valid | input | 1 | MAC transmit word offered |
| mac_tx_ready | output | 1 | One-cycle accept strobe, once per group |
| mac_tx_ctrl | input | 4 | MAC transmit control bits |
| mac_tx_data | input | 32 | MAC transmit data |
| phy_tx_ctrl | output | 4 | Line transmit control bits |
| phy_tx_data | output | 32 | Line transmit data |
| phy_rx_ctrl | input | 4 | Line receive control bits |
| phy_rx_data | input | 32 | Line receive data |
| mac_rx_valid | output | 1 | One-cycle strobe for a kept receive word |
| mac_rx_ctrl | output | 4 | Kept receive control bits |
| mac_rx_data | output | 32 | Kept receive data |

## Verification
Cycle 0 is a cycle in which the bench sees `mac_tx_ready` high. An accepted or idle transmit word then shows on the line lane in cycles 1 through N. The kept receive word and its valid strobe show in cycle 1 only, and the next ready strobe is due in cycle N. When the speed changes, the old word fills cycles 1 through N_old, idle words fill the next N_new cycles, and ready returns in cycle N_old+N_new, wherever inside the old group the code was changed. Every check steps one falling edge at a time from a known ready cycle. Each output is sampled at the falling edge of the exact cycle index where these rules place it.

// File: rtl/rra_pkg.sv
package rra_pkg;
  localparam int LANE_BYTES = 4;
  localparam int DATA_W     = 8 * LANE_BYTES;
  localparam int CTRL_W     = LANE_BYTES;
  localparam logic [7:0] IDLE_BYTE = 8'h07;

  typedef logic [2:0] speed_t;
  localparam speed_t SPD_10M  = 3'd0;
  localparam speed_t SPD_100M = 3'd1;
  localparam speed_t SPD_1G   = 3'd2;
  localparam speed_t SPD_2G5  = 3'd3;
  localparam speed_t SPD_5G   = 3'd4;
  localparam speed_t SPD_10G  = 3'd5;

  typedef struct packed {
    logic [CTRL_W-1:0] ctl;
    logic [DATA_W-1:0] dat;
  } lane_t;

  function automatic lane_t idle_lane();
    lane_t w;
    w.ctl = '1;
    w.dat = {LANE_BYTES{IDLE_BYTE}};
    return w;
  endfunction
endpackage

// File: rtl/rra_pacer.sv
module rra_pacer
  import rra_pkg::*;
#(
  parameter int     F_10M   = 1000,
  parameter int     F_100M  = 100,
  parameter int     F_1G    = 10,
  parameter int     F_2G5   = 4,
  parameter int     F_5G    = 2,
  parameter speed_t SPD_RST = SPD_10G,
  localparam int    CNT_W   = $clog2(F_10M + 1)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  speed_t spd_req,
  output logic   grp_start,
  output logic   realign,
  output logic   slot
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  speed_t           active;
  logic             at_last;

  always_comb begin
    case (active)
      SPD_10M:  last = CNT_W'(F_10M - 1);
      SPD_100M: last = CNT_W'(F_100M - 1);
      SPD_1G:   last = CNT_W'(F_1G - 1);
      SPD_2G5:  last = CNT_W'(F_2G5 - 1);
      SPD_5G:   last = CNT_W'(F_5G - 1);
      default:  last = '0;
    endcase
  end

  assign at_last   = (cnt == last);
  assign grp_start = (cnt == '0);
  assign slot      = grp_start && !realign;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      active  <= SPD_RST;
      realign <= 1'b0;
    end else if (at_last) begin
      cnt <= '0;
      if (spd_req != active) begin
        active  <= spd_req;
        realign <= 1'b1;
      end else begin
        realign <= 1'b0;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last); // R2
  AST_SPEED_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active) |-> $past(at_last)); // R7
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active) |-> (cnt == '0 && realign)); // R8
  AST_READY_ONE_IN_N: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && last != '0) |=> !slot); // R3
endmodule

// File: rtl/rra_tx_hold.sv
module rra_tx_hold
  import rra_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  grp_start,
  input  logic  realign,
  input  logic  in_valid,
  input  lane_t in_lane,
  output lane_t out_lane
);
  lane_t hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= idle_lane();
    end else if (grp_start) begin
      hold <= (in_valid && !realign) ? in_lane : idle_lane();
    end
  end

  assign out_lane = hold;

  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(grp_start) |-> $stable(hold)); // R4
  AST_TX_IDLE_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_start && realign) |=> (hold == idle_lane())); // R8
endmodule

// File: rtl/rra_rx_pick.sv
module rra_rx_pick
  import rra_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  slot,
  input  lane_t in_lane,
  output logic  out_valid,
  output lane_t out_lane
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_lane  <= idle_lane();
    end else begin
      out_valid <= slot;
      if (slot) out_lane <= in_lane;
    end
  end

  AST_RX_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    !slot |=> $stable(out_lane)); // R6
endmodule

// File: rtl/rate_repl_adapter.sv
module rate_repl_adapter
  import rra_pkg::*;
#(
  parameter int     F_10M   = 1000,
  parameter int     F_100M  = 100,
  parameter int     F_1G    = 10,
  parameter int     F_2G5   = 4,
  parameter int     F_5G    = 2,
  parameter speed_t SPD_RST = SPD_10G
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        spd_sel,
  input  logic              mac_tx_valid,
  output logic              mac_tx_ready,
  input  logic [CTRL_W-1:0] mac_tx_ctrl,
  input  logic [DATA_W-1:0] mac_tx_data,
  output logic [CTRL_W-1:0] phy_tx_ctrl,
  output logic [DATA_W-1:0] phy_tx_data,
  input  logic [CTRL_W-1:0] phy_rx_ctrl,
  input  logic [DATA_W-1:0] phy_rx_data,
  output logic              mac_rx_valid,
  output logic [CTRL_W-1:0] mac_rx_ctrl,
  output logic [DATA_W-1:0] mac_rx_data
);
  logic  grp_start, realign, slot;
  lane_t tx_in, tx_out, rx_in, rx_out;

  rra_pacer #(
    .F_10M(F_10M), .F_100M(F_100M), .F_1G(F_1G),
    .F_2G5(F_2G5), .F_5G(F_5G), .SPD_RST(SPD_RST)
  ) u_pacer (
    .clk(clk), .rst_n(rst_n), .spd_req(spd_sel),
    .grp_start(grp_start), .realign(realign), .slot(slot)
  );

  assign tx_in = '{ctl: mac_tx_ctrl, dat: mac_tx_data};

  rra_tx_hold u_tx (
    .clk(clk), .rst_n(rst_n), .grp_start(grp_start), .realign(realign),
    .in_valid(mac_tx_valid), .in_lane(tx_in), .out_lane(tx_out)
  );

  assign rx_in = '{ctl: phy_rx_ctrl, dat: phy_rx_data};

  rra_rx_pick u_rx (
    .clk(clk), .rst_n(rst_n), .slot(slot), .in_lane(rx_in),
    .out_valid(mac_rx_valid), .out_lane(rx_out)
  );

  assign mac_tx_ready = slot;
  assign phy_tx_ctrl  = tx_out.ctl;
  assign phy_tx_data  = tx_out.dat;
  assign mac_rx_ctrl  = rx_out.ctl;
  assign mac_rx_data  = rx_out.dat;

  AST_TX_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_tx_valid && mac_tx_ready) |=>
      (phy_tx_data == $past(mac_tx_data) && phy_tx_ctrl == $past(mac_tx_ctrl))); // R4
  AST_RX_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mac_rx_valid |-> $past(mac_tx_ready)); // R6
endmodule

// File: tb/sim_rate_repl_adapter.sv
module sim_rate_repl_adapter;
  localparam int CLK_PER = 10;
  localparam logic [3:0]  IDL_C = 4'hF;
  localparam logic [31:0] IDL_D = 32'h0707_0707;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  spd_sel;
  logic        mac_tx_valid, mac_tx_ready;
  logic [3:0]  mac_tx_ctrl, phy_tx_ctrl, phy_rx_ctrl, mac_rx_ctrl;
  logic [31:0] mac_tx_data, phy_tx_data, phy_rx_data, mac_rx_data;
  logic        mac_rx_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  rate_repl_adapter u0 (
    .clk(clk), .rst_n(rst_n), .spd_sel(spd_sel),
    .mac_tx_valid(mac_tx_valid), .mac_tx_ready(mac_tx_ready),
    .mac_tx_ctrl(mac_tx_ctrl), .mac_tx_data(mac_tx_data),
    .phy_tx_ctrl(phy_tx_ctrl), .phy_tx_data(phy_tx_data),
    .phy_rx_ctrl(phy_rx_ctrl), .phy_rx_data(phy_rx_data),
    .mac_rx_valid(mac_rx_valid), .mac_rx_ctrl(mac_rx_ctrl), .mac_rx_data(mac_rx_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Entry and exit at a falling edge where ready is high (cycle 0 / cycle N).
  task automatic run_group(input int n, input bit vld, input logic [35:0] txw,
                           input logic [35:0] rxw, input string rtag);
    logic [35:0] exp_tx;
    exp_tx = vld ? txw : {IDL_C, IDL_D};
    mac_tx_valid = vld;
    {mac_tx_ctrl, mac_tx_data} = txw;
    {phy_rx_ctrl, phy_rx_data} = rxw;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      chk({phy_tx_ctrl, phy_tx_data} == exp_tx, vld ? "R4" : "R5",
          64'({phy_tx_ctrl, phy_tx_data}), 64'(exp_tx));
      chk(mac_tx_ready == (i == n), rtag, 64'(mac_tx_ready), 64'(i == n));
      chk(mac_rx_valid == (i == 1), "R6", 64'(mac_rx_valid), 64'(i == 1));
      if (i == 1)
        chk({mac_rx_ctrl, mac_rx_data} == rxw, "R6",
            64'({mac_rx_ctrl, mac_rx_data}), 64'(rxw));
      mac_tx_valid = 1'b0;
      {phy_rx_ctrl, phy_rx_data} = {4'h5, 32'hE000_0000 | 32'(i)};
    end
  endtask

  // Speed switch: code written in cycle 'at' of the old group (at < n_old).
  task automatic switch_speed(input int n_old, input int n_new, input logic [2:0] code,
                              input int at, input logic [35:0] txw, input logic [35:0] rxw);
    logic [35:0] exp_tx;
    mac_tx_valid = 1'b1;
    {mac_tx_ctrl, mac_tx_data} = txw;
    {phy_rx_ctrl, phy_rx_data} = rxw;
    if (at == 0) spd_sel = code;
    for (int i = 1; i <= n_old + n_new; i++) begin
      @(negedge clk);
      exp_tx = (i <= n_old) ? txw : {IDL_C, IDL_D};
      chk({phy_tx_ctrl, phy_tx_data} == exp_tx, (i <= n_old) ? "R4" : "R8",
          64'({phy_tx_ctrl, phy_tx_data}), 64'(exp_tx));
      chk(mac_tx_ready == (i == n_old + n_new), (at == 0) ? "R8" : "R7",
          64'(mac_tx_ready), 64'(i == n_old + n_new));
      chk(mac_rx_valid == (i == 1), (i == 1) ? "R6" : "R8", 64'(mac_rx_valid), 64'(i == 1));
      if (i == 1)
        chk({mac_rx_ctrl, mac_rx_data} == rxw, "R6",
            64'({mac_rx_ctrl, mac_rx_data}), 64'(rxw));
      // Offered words during realignment must be ignored (R8).
      mac_tx_valid = 1'b1;
      {mac_tx_ctrl, mac_tx_data} = {4'h3, 32'hBAD0_0000 | 32'(i)};
      {phy_rx_ctrl, phy_rx_data} = {4'hA, 32'hC000_0000 | 32'(i)};
      if (i == at) spd_sel = code;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    spd_sel = 3'd5;
    mac_tx_valid = 1'b0;
    mac_tx_ctrl = '0; mac_tx_data = '0;
    phy_rx_ctrl = '0; phy_rx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(mac_tx_ready == 1'b1, "R1", 64'(mac_tx_ready), 64'd1);
    chk(mac_rx_valid == 1'b0, "R1", 64'(mac_rx_valid), 64'd0);
    chk({phy_tx_ctrl, phy_tx_data} == {IDL_C, IDL_D}, "R1",
        64'({phy_tx_ctrl, phy_tx_data}), 64'({IDL_C, IDL_D}));

    run_group(1, 1'b1, {4'h1, 32'h1111_0001}, {4'h0, 32'hAA00_0001}, "R1 R2");
    run_group(1, 1'b0, {4'h1, 32'h1111_0002}, {4'h0, 32'hAA00_0002}, "R3");
    switch_speed(1, 2, 3'd4, 0, {4'h2, 32'h2222_0000}, {4'h1, 32'hAA00_0003});
    run_group(2, 1'b1, {4'h0, 32'h5555_0001}, {4'h0, 32'hAA00_0004}, "R2");
    run_group(2, 1'b0, {4'h0, 32'h5555_0002}, {4'h8, 32'hAA00_0005}, "R3");
    switch_speed(2, 4, 3'd3, 1, {4'h4, 32'h2525_0000}, {4'h0, 32'hAA00_0006});
    run_group(4, 1'b1, {4'h0, 32'h2525_0001}, {4'h0, 32'hAA00_0007}, "R2");
    run_group(4, 1'b0, {4'h0, 32'h2525_0002}, {4'h0, 32'hAA00_0008}, "R3");
    switch_speed(4, 10, 3'd2, 2, {4'h0, 32'h1010_0000}, {4'h0, 32'hAA00_0009});
    run_group(10, 1'b1, {4'hC, 32'h1010_0001}, {4'h0, 32'hAA00_000A}, "R2");
    switch_speed(10, 100, 3'd1, 7, {4'h0, 32'h0100_0000}, {4'h0, 32'hAA00_000B});
    run_group(100, 1'b1, {4'h0, 32'h0100_0001}, {4'h3, 32'hAA00_000C}, "R2");
    switch_speed(100, 1000, 3'd0, 50, {4'h0, 32'h0010_0000}, {4'h0, 32'hAA00_000D});
    run_group(1000, 1'b1, {4'h0, 32'h0010_0001}, {4'h0, 32'hAA00_000E}, "R2");
    run_group(1000, 1'b0, {4'h0, 32'h0010_0002}, {4'h0, 32'hAA00_000F}, "R3");
    switch_speed(1000, 1, 3'd5, 0, {4'h0, 32'hFEED_0000}, {4'h0, 32'hAA00_0010});
    run_group(1, 1'b1, {4'h0, 32'hFEED_0001}, {4'h0, 32'hAA00_0011}, "R2");
    switch_speed(1, 1, 3'd7, 0, {4'h0, 32'h7777_0000}, {4'h0, 32'hAA00_0012});
    run_group(1, 1'b1, {4'h6, 32'h7777_0001}, {4'h0, 32'hAA00_0013}, "R2");
    run_group(1, 1'b0, {4'h6, 32'h7777_0002}, {4'h0, 32'hAA00_0014}, "R2");
    done = 1'b1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      report();
    end
  end
endmodule